// File: doc/BRIEF.md
# UART Receive Path with Two-Stage Holding Queue

This block is the receive half of a serial port. It takes an asynchronous serial line, clocked by the system clock, together with a baud tick that pulses sixteen times per bit period. From these it rebuilds characters. Each character has eight data bits followed by a ninth data bit, and the ninth bit can be removed by a parameter. A finished character goes into a small queue of two places. The first place is a top register that drives the read port. The second is one hidden stage behind it. The shift register can hold a third character while it completes.

Each stored character keeps its own stop-bit error and ninth bit. The `frame_err` and `rd_ninth` outputs always describe the character now in the top register, and they change only when that register is reloaded. Software must therefore sample the status before it pulses `rd_stb`. Reading the last queued character clears `data_avail`, but a set error flag stays set until a character with a good stop bit arrives. Dropping `rx_en` empties the queue and clears all error state.

The deserializer runs through the states SP_IDLE, SP_START, SP_DATA and SP_STOP:

- SP_IDLE moves to SP_START when it sees the line low on a tick.
- SP_START moves to SP_DATA if the line is still low at mid-bit. If the line is high there, it returns to SP_IDLE.
- SP_DATA moves to SP_STOP after the last data bit.
- SP_STOP returns to SP_IDLE when it samples the stop bit.

The queue runs through QS_EMPTY, QS_ONE and QS_TWO. A new character moves it up one state. A read moves it down one state. A read and a new character in the same cycle keep the occupancy the same.

Top module: `uart_rx_holdq`

## Requirements
- R1: The line is oversampled at 16 baud ticks per bit. A low level seen on a tick in idle starts a character. That character is kept only if the line is still low on the 8th tick after detection. A shorter low pulse produces no character.
- R2: Data bits arrive least significant bit first. They are sampled every 16 ticks after the start-bit check. The first DATA_W bits appear on `rd_data[DATA_W-1:0]`, and the following bit appears on `rd_ninth`.
- R3: While `data_avail` is high and `rd_stb` is low, `rd_data`, `rd_ninth` and `frame_err` keep their values. This holds even when a new character lands in the hidden stage.
- R4: A read while the hidden stage is occupied moves that character into the top register on the next cycle. Its own `frame_err` and `rd_ninth` move with it.
- R5: A read while the hidden stage is empty clears `data_avail` on the next cycle and leaves `frame_err` unchanged. A read while `data_avail` is low has no effect.
- R6: With the queue empty, `data_avail` rises on the clock after the tick on which the stop bit is sampled. That tick is the 168th tick after start detection.
- R7: A character whose stop-bit sample is low loads with `frame_err`=1. The flag stays 1 through any reads until a character with a high stop bit loads into the top register.
- R8: A character that completes while both stages are full, with no read in that cycle, is discarded. It sets `overrun`, which stays 1 until the receiver is disabled. The queued characters are kept.
- R9: While `rx_en` is low, the queue is emptied, `frame_err` and `overrun` are cleared, and the line is ignored.
- R10: After reset, `data_avail`, `frame_err`, `rd_ninth`, `overrun` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the queue and error state |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| rx_line | input | 1 | Serial receive line, already synchronous to clk |
| rd_stb | input | 1 | Read strobe; consumes the top character |
| rd_data | output | DATA_W | Data bits of the top character |
| rd_ninth | output | 1 | Ninth data bit of the top character |
| data_avail | output | 1 | Top register holds an unread character |
| frame_err | output | 1 | Stop-bit error of the top character, sticky across reads that leave the queue empty |
| overrun | output | 1 | A character was lost because the queue was full |

## Verification
The assertions assume three things about the inputs:

- `rx_line` is already synchronous to `clk`.
- `baud_tick` is a single-cycle pulse.
- `rd_stb` is only meaningful as a one-cycle strobe.

The stimulus respects these assumptions:

- It changes the line and the strobe on the falling clock edge.
- It generates the tick from a free-running divider of four clocks.
- It leaves at least one full bit period of idle-high line after each stop bit. This lets a bad stop bit that is mistaken for a new start be rejected at mid-bit before the next real frame begins.

// File: rtl/urxq_pkg.sv
`timescale 1ns/1ps
package urxq_pkg;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_START,
        SP_DATA,
        SP_STOP
    } samp_state_e;

    typedef enum logic [1:0] {
        QS_EMPTY,
        QS_ONE,
        QS_TWO
    } q_state_e;

endpackage

// File: rtl/urxq_deser.sv
`timescale 1ns/1ps
module urxq_deser
    import urxq_pkg::*;
#(
    parameter int NBITS = 9,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rx,
    output logic             done,
    output logic [NBITS-1:0] word,
    output logic             bad
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(NBITS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

    samp_state_e      st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [BW-1:0]    bit_q, bit_d;
    logic [NBITS-1:0] sh_q, sh_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SP_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            bit_q <= bit_d;
            sh_q  <= sh_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        bit_d = bit_q;
        sh_d  = sh_q;
        if (!en) begin
            st_d  = SP_IDLE;
            cnt_d = '0;
            bit_d = '0;
        end else if (tick) begin
            unique case (st_q)
                SP_IDLE: begin
                    if (!rx) begin
                        st_d  = SP_START;
                        cnt_d = '0;
                    end
                end
                SP_START: begin
                    if (cnt_q == CNT_HALF) begin
                        cnt_d = '0;
                        bit_d = '0;
                        st_d  = rx ? SP_IDLE : SP_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SP_DATA: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = '0;
                        sh_d  = {rx, sh_q[NBITS-1:1]};
                        if (bit_q == BIT_LAST) begin
                            st_d = SP_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                SP_STOP: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = '0;
                        st_d  = SP_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = SP_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done = en && tick && (st_q == SP_STOP) && (cnt_q == CNT_LAST);
        word = sh_q;
        bad  = ~rx;
    end

endmodule

// File: rtl/urxq_hold.sv
`timescale 1ns/1ps
module urxq_hold
    import urxq_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         push_bad,
    input  logic         pop,
    output logic [W-1:0] top_word,
    output logic         top_bad,
    output logic         avail,
    output logic         buf_full,
    output logic         overrun
);
    q_state_e     st_q, st_d;
    logic         ld_push, ld_from_buf, ld_buf, ovf_set;
    logic [W-1:0] top_q, buf_q;
    logic         top_bad_q, buf_bad_q, ovr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= QS_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and load controls
    always_comb begin
        st_d        = st_q;
        ld_push     = 1'b0;
        ld_from_buf = 1'b0;
        ld_buf      = 1'b0;
        ovf_set     = 1'b0;
        unique case (st_q)
            QS_EMPTY: begin
                if (push) begin
                    st_d    = QS_ONE;
                    ld_push = 1'b1;
                end
            end
            QS_ONE: begin
                if (pop && push) begin
                    ld_push = 1'b1;
                end else if (pop) begin
                    st_d = QS_EMPTY;
                end else if (push) begin
                    st_d   = QS_TWO;
                    ld_buf = 1'b1;
                end
            end
            QS_TWO: begin
                if (pop && push) begin
                    ld_from_buf = 1'b1;
                    ld_buf      = 1'b1;
                end else if (pop) begin
                    st_d        = QS_ONE;
                    ld_from_buf = 1'b1;
                end else if (push) begin
                    ovf_set = 1'b1;
                end
            end
            default: st_d = QS_EMPTY;
        endcase
        if (!en) begin
            st_d        = QS_EMPTY;
            ld_push     = 1'b0;
            ld_from_buf = 1'b0;
            ld_buf      = 1'b0;
            ovf_set     = 1'b0;
        end
    end

    // storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q     <= '0;
            top_bad_q <= 1'b0;
            buf_q     <= '0;
            buf_bad_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else if (!en) begin
            top_q     <= '0;
            top_bad_q <= 1'b0;
            buf_bad_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (ld_push) begin
                top_q     <= push_word;
                top_bad_q <= push_bad;
            end else if (ld_from_buf) begin
                top_q     <= buf_q;
                top_bad_q <= buf_bad_q;
            end
            if (ld_buf) begin
                buf_q     <= push_word;
                buf_bad_q <= push_bad;
            end
            if (ovf_set) begin
                ovr_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        top_word = top_q;
        top_bad  = top_bad_q;
        avail    = (st_q != QS_EMPTY);
        buf_full = (st_q == QS_TWO);
        overrun  = ovr_q;
    end

endmodule

// File: rtl/uart_rx_holdq.sv
`timescale 1ns/1ps
module uart_rx_holdq #(
    parameter int DATA_W   = 8,
    parameter int NINE_BIT = 1,
    parameter int OVS      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              baud_tick,
    input  logic              rx_line,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ninth,
    output logic              data_avail,
    output logic              frame_err,
    output logic              overrun
);
    localparam int NBITS = DATA_W + NINE_BIT;

    logic             char_done;
    logic [NBITS-1:0] char_word;
    logic             char_bad;
    logic [NBITS-1:0] q_top_word;
    logic             q_buf_full;

    urxq_deser #(
        .NBITS (NBITS),
        .OVS   (OVS)
    ) deser_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .tick  (baud_tick),
        .rx    (rx_line),
        .done  (char_done),
        .word  (char_word),
        .bad   (char_bad)
    );

    urxq_hold #(
        .W (NBITS)
    ) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .push      (char_done),
        .push_word (char_word),
        .push_bad  (char_bad),
        .pop       (rd_stb),
        .top_word  (q_top_word),
        .top_bad   (frame_err),
        .avail     (data_avail),
        .buf_full  (q_buf_full),
        .overrun   (overrun)
    );

    assign rd_data = q_top_word[DATA_W-1:0];

    generate
        if (NINE_BIT != 0) begin : g_ninth
            assign rd_ninth = q_top_word[NBITS-1];
        end else begin : g_no_ninth
            assign rd_ninth = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/urxq_checker.sv
`timescale 1ns/1ps
module urxq_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ninth,
    input logic              data_avail,
    input logic              frame_err,
    input logic              overrun,
    input logic              push,
    input logic              buf_full
);

    AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && data_avail && !rd_stb) |=>
        ($stable(rd_data) && $stable(rd_ninth) && $stable(frame_err))); // R3

    AST_BUF_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_stb && buf_full) |=> data_avail); // R4

    AST_LAST_READ_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_stb && data_avail && !buf_full && !push) |=>
        (!data_avail && $stable(frame_err))); // R5

    AST_AVAIL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && push && !data_avail) |=> data_avail); // R6

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && overrun) |=> overrun); // R8

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !overrun && !(push && buf_full && !rd_stb)) |=> !overrun); // R8

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en) |=> (!data_avail && !frame_err && !overrun)); // R9

endmodule

bind uart_rx_holdq urxq_checker #(
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .rd_ninth   (rd_ninth),
    .data_avail (data_avail),
    .frame_err  (frame_err),
    .overrun    (overrun),
    .push       (char_done),
    .buf_full   (q_buf_full)
);

// File: tb/uart_rx_holdq_tb_top.sv
`timescale 1ns/1ps
module uart_rx_holdq_tb_top;

    localparam int BITCLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ninth, data_avail, frame_err, overrun;

    logic [1:0] tdiv = 2'd0;
    int         pcyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
        pcyc      <= pcyc + 1;
    end

    uart_rx_holdq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .baud_tick  (baud_tick),
        .rx_line    (rx_line),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .rd_ninth   (rd_ninth),
        .data_avail (data_avail),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Sends start, 9 data bits LSB first, stop, then one bit of idle.
    task automatic send_frame(input logic [8:0] w, input logic stop_val, input bit tchk);
        logic [10:0] bits;
        int          exp_c;
        exp_c = -1;
        bits  = {stop_val, w, 1'b0};
        for (int b = 0; b < 12; b++) begin
            rx_line = (b < 11) ? bits[b] : 1'b1;
            for (int c = 0; c < BITCLK; c++) begin
                if (b == 0 && exp_c < 0 && baud_tick) exp_c = pcyc + 673;
                if (tchk && exp_c >= 0 && pcyc == exp_c - 1)
                    chk("R6", "avail before stop sample", {31'd0, data_avail}, 32'd0);
                if (tchk && exp_c >= 0 && pcyc == exp_c)
                    chk("R6", "avail after stop sample", {31'd0, data_avail}, 32'd1);
                @(negedge clk);
            end
        end
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic chk_top(input string req, input logic [8:0] w, input logic fe);
        chk(req, "data_avail", {31'd0, data_avail}, 32'd1);
        chk(req, "rd_data", {24'd0, rd_data}, {24'd0, w[7:0]});
        chk(req, "rd_ninth", {31'd0, rd_ninth}, {31'd0, w[8]});
        chk(req, "frame_err", {31'd0, frame_err}, {31'd0, fe});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R10", "avail at reset", {31'd0, data_avail}, 32'd0);
        chk("R10", "ferr at reset", {31'd0, frame_err}, 32'd0);
        chk("R10", "ovr at reset", {31'd0, overrun}, 32'd0);
        chk("R10", "data at reset", {23'd0, rd_ninth, rd_data}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 / R6 sweep over 9-bit words, queue empty each time
        for (int i = 0; i < 40; i++) begin
            logic [8:0] w;
            w = (i == 0) ? 9'h000 : (i == 1) ? 9'h1FF : 9'((i * 83 + 29) % 512);
            send_frame(w, 1'b1, 1'b1);
            chk_top("R2", w, 1'b0);
            do_read();
            chk("R5", "avail after last read", {31'd0, data_avail}, 32'd0);
        end

        // R3 / R4 / R5 / R7: good top, bad character into hidden stage
        send_frame(9'h0A5, 1'b1, 1'b1);
        send_frame(9'h13C, 1'b0, 1'b0);
        chk_top("R3", 9'h0A5, 1'b0);
        repeat (50) @(negedge clk);
        chk_top("R3", 9'h0A5, 1'b0);
        do_read();
        chk_top("R4", 9'h13C, 1'b1);
        do_read();
        chk("R5", "avail cleared", {31'd0, data_avail}, 32'd0);
        chk("R5", "ferr kept", {31'd0, frame_err}, 32'd1);
        do_read();
        chk("R5", "empty read avail", {31'd0, data_avail}, 32'd0);
        chk("R7", "empty read ferr", {31'd0, frame_err}, 32'd1);
        send_frame(9'h042, 1'b1, 1'b1);
        chk_top("R7", 9'h042, 1'b0);
        do_read();

        // R7: two bad characters keep the flag set through both reads
        send_frame(9'h111, 1'b0, 1'b1);
        send_frame(9'h0EE, 1'b0, 1'b0);
        chk_top("R7", 9'h111, 1'b1);
        do_read();
        chk_top("R7", 9'h0EE, 1'b1);
        do_read();
        chk("R7", "avail after 2 bad", {31'd0, data_avail}, 32'd0);
        chk("R7", "ferr after 2 bad", {31'd0, frame_err}, 32'd1);
        send_frame(9'h101, 1'b1, 1'b1);
        chk_top("R7", 9'h101, 1'b0);
        do_read();

        // R4: bad top then good buffered character
        send_frame(9'h0F0, 1'b0, 1'b1);
        send_frame(9'h00F, 1'b1, 1'b0);
        chk_top("R4", 9'h0F0, 1'b1);
        do_read();
        chk_top("R4", 9'h00F, 1'b0);
        do_read();

        // R8: overrun
        send_frame(9'h031, 1'b1, 1'b1);
        chk("R8", "no ovr at 1", {31'd0, overrun}, 32'd0);
        send_frame(9'h032, 1'b1, 1'b0);
        chk("R8", "no ovr at 2", {31'd0, overrun}, 32'd0);
        send_frame(9'h133, 1'b0, 1'b0);
        chk("R8", "ovr at 3", {31'd0, overrun}, 32'd1);
        chk_top("R8", 9'h031, 1'b0);
        do_read();
        chk_top("R8", 9'h032, 1'b0);
        do_read();
        chk("R8", "third dropped", {31'd0, data_avail}, 32'd0);
        chk("R8", "ovr sticky", {31'd0, overrun}, 32'd1);
        send_frame(9'h0C3, 1'b1, 1'b1);
        chk_top("R8", 9'h0C3, 1'b0);
        chk("R8", "ovr still set", {31'd0, overrun}, 32'd1);
        do_read();

        // R9: disable flushes a bad queued character and the overrun
        send_frame(9'h155, 1'b0, 1'b1);
        send_frame(9'h0AA, 1'b1, 1'b0);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R9", "avail flushed", {31'd0, data_avail}, 32'd0);
        chk("R9", "ferr flushed", {31'd0, frame_err}, 32'd0);
        chk("R9", "ovr flushed", {31'd0, overrun}, 32'd0);
        send_frame(9'h077, 1'b1, 1'b0);
        chk("R9", "line ignored", {31'd0, data_avail}, 32'd0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(9'h1E1, 1'b1, 1'b1);
        chk_top("R9", 9'h1E1, 1'b0);
        do_read();

        // R1: short low pulse is rejected, a real frame still arrives
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (800) @(negedge clk);
        chk("R1", "glitch rejected", {31'd0, data_avail}, 32'd0);
        send_frame(9'h0D2, 1'b1, 1'b1);
        chk_top("R1", 9'h0D2, 1'b0);
        do_read();

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1520000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule